// File: doc/BRIEF.md
# Descriptor-Chained Frame Fetcher

This block feeds a display controller with the words it needs for each frame. Software places a chain of four-word descriptors in memory and hands the fetcher the address of the first one with a single start pulse. The fetcher reads the descriptor over a word-read memory port. It then reads the buffer the descriptor points at, in fixed-size bursts, and moves on to the descriptor named by the link word. A chain may close on itself, so the block keeps fetching until reset. One such loop is a palette load followed by a frame, then back to the palette. Another is a single frame descriptor that links to itself.

Each descriptor holds four words, read in this order: the link to the next descriptor, the source address, a frame tag and a command word. The command word gives the buffer length in words. It also marks the buffer as palette data or frame data, and asks for a start-of-frame pulse, an end-of-frame pulse, or both. Palette words go out on a RAM write port. Frame words enter an internal pixel FIFO that the display side drains with a pop strobe. An optional underrun guard keeps the pixel stream valid by repeating the last word when the FIFO is empty, and it records that this happened.

Top module: `frame_fetch_top`

## Requirements
- R1: A start pulse while idle loads startAddr as the descriptor address. The fetcher then reads the four descriptor words at that address, +4, +8 and +12, in that order. The memory returns memRdData in the cycle after the memRdEn cycle.
- R2: After a descriptor with length L (command bits [23:0]), the fetcher reads L consecutive words from the source address, stepping by 4. It then reads the descriptor at the link address. Reads are issued in back-to-back runs of one burst: burstSel 0 gives 4 words, 1 gives 8 words, and 2 or 3 give 16 words.
- R3: A buffer whose command bit 28 is set is palette data. Its k-th word is written with palWrEn, palWrAddr = k (counted from 0 for each palette descriptor) and palWrData = the memory word, in the cycle the read data returns.
- R4: Frame words (command bit 28 clear) appear in order at pixData two cycles after their read cycle. pixValid is high while the FIFO holds a word, and pixPop removes the head word at the clock edge.
- R5: A frame burst starts only when the FIFO has room for the whole burst, so the FIFO never holds more than FIFO_DEPTH words.
- R6: When command bit 31 is set, sofIrq pulses for one cycle once the descriptor is loaded.
- R7: When command bit 30 is set, eofIrq pulses for one cycle two cycles after the last data read of that buffer. At that point the status outputs still show that descriptor.
- R8: A length of zero issues no data reads. The fetcher goes straight to the link address and still raises any requested end-of-frame pulse.
- R9: curDescAddr, curSource and curFrameId take the address, source word and tag word of a descriptor when it is loaded. They are visible in the sofIrq cycle.
- R10: With underrunProt high, a pop while the FIFO is empty keeps pixValid high with pixData equal to the last popped word, and it sets underrunFlag. The flag stays set until the next start. With underrunProt low, an empty FIFO drives pixValid low, a pop then has no effect, and the flag stays clear.
- R11: After reset, memRdEn, palWrEn, sofIrq, eofIrq, underrunFlag and the status outputs are all zero, and pixValid is low while underrunProt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a chain (taken when idle) |
| startAddr | input | 32 | Byte address of the first descriptor |
| burstSel | input | 2 | Burst length code |
| underrunProt | input | 1 | Repeat the last word on an empty FIFO |
| memRdEn | output | 1 | Word read request |
| memAddr | output | 32 | Byte address of the read |
| memRdData | input | 32 | Read data, one cycle after the request |
| palWrEn | output | 1 | Palette RAM write strobe |
| palWrAddr | output | PAL_AW | Palette word index |
| palWrData | output | 32 | Palette word (two 16-bit entries) |
| pixPop | input | 1 | Consumer takes the head word |
| pixValid | output | 1 | pixData is usable |
| pixData | output | 32 | Head frame word |
| sofIrq | output | 1 | Start-of-frame pulse |
| eofIrq | output | 1 | End-of-frame pulse |
| underrunFlag | output | 1 | Sticky empty-pop record |
| curDescAddr | output | 32 | Address of the loaded descriptor |
| curSource | output | 32 | Source word of the loaded descriptor |
| curFrameId | output | 32 | Tag word of the loaded descriptor |

## Verification
A corrupt descriptor index or link register shows up at the ports on the very next read: memAddr leaves the expected address stream, and the bench compares that stream on every request. A wrong burst counter or room check changes how long the runs of back-to-back reads are. It also pushes the modelled FIFO occupancy past its depth, which is caught within one burst. A broken response stage or FIFO pointer shows within two cycles as a wrong palWrEn cycle or a pixData that differs from the bench's queue. Interrupt and status faults surface in the pulse cycle itself.

// File: rtl/frame_fetch_pkg.sv
package frame_fetch_pkg;

  localparam int CMD_SOF_BIT = 31;
  localparam int CMD_EOF_BIT = 30;
  localparam int CMD_PAL_BIT = 28;
  localparam int LEN_W       = 24;

  typedef enum logic [2:0] {
    S_IDLE, S_DRD, S_DWT, S_LOAD, S_DATA, S_BURST, S_WAIT
  } fetch_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic descIssue;
    logic descCapture;
    logic loadDesc;
    logic burstInit;
    logic dataIssue;
    logic followNext;
  } ctrl_stb_t;

  // conditions from datapath to control
  typedef struct packed {
    logic descLast;
    logic lenZero;
    logic isPal;
    logic fifoRoom;
    logic lastIssue;
    logic remainZero;
    logic wantSof;
    logic wantEof;
  } dp_info_t;

  function automatic logic [4:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/pix_fifo.sv
module pix_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = store[rdPtr];
  assign empty = (count == '0);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> (count < CW'(DEPTH)));

  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));

endmodule

// File: rtl/frame_fetch_dpath.sv
module frame_fetch_dpath
  import frame_fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int PAL_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_stb_t         stb,
  output dp_info_t          info,
  input  logic [31:0]       startAddr,
  input  logic [1:0]        burstSel,
  input  logic              underrunProt,
  output logic              memRdEn,
  output logic [31:0]       memAddr,
  input  logic [31:0]       memRdData,
  output logic              palWrEn,
  output logic [PAL_AW-1:0] palWrAddr,
  output logic [31:0]       palWrData,
  input  logic              pixPop,
  output logic              pixValid,
  output logic [31:0]       pixData,
  output logic              underrunFlag,
  output logic [31:0]       curDescAddr,
  output logic [31:0]       curSource,
  output logic [31:0]       curFrameId
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [31:0]       descPtr, linkField, srcField, tagField, srcPtr, lastWord;
  logic [1:0]        descIdx;
  logic [LEN_W-1:0]  lenField, remain;
  logic              cmdSof, cmdEof, cmdPal;
  logic [4:0]        burstLeft, burstSize;
  logic [PAL_AW-1:0] palIdx;
  logic              rspValid, rspPal;
  logic              fifoPush, fifoPop, fifoEmpty;
  logic [31:0]       fifoHead;
  logic [CW-1:0]     fifoCount;

  assign burstSize = burst_words(burstSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr <= '0; descIdx <= '0;
      linkField <= '0; srcField <= '0; tagField <= '0;
      lenField <= '0; cmdSof <= 1'b0; cmdEof <= 1'b0; cmdPal <= 1'b0;
      srcPtr <= '0; remain <= '0; burstLeft <= '0; palIdx <= '0;
      curDescAddr <= '0; curSource <= '0; curFrameId <= '0;
      rspValid <= 1'b0; rspPal <= 1'b0;
    end else begin
      if (stb.start) begin
        descPtr <= startAddr;
        descIdx <= '0;
      end
      if (stb.followNext) begin
        descPtr <= linkField;
        descIdx <= '0;
      end
      if (stb.descCapture) begin
        descIdx <= descIdx + 1'b1;
        case (descIdx)
          2'd0: linkField <= memRdData;
          2'd1: srcField  <= memRdData;
          2'd2: tagField  <= memRdData;
          default: begin
            lenField <= memRdData[LEN_W-1:0];
            cmdSof   <= memRdData[CMD_SOF_BIT];
            cmdEof   <= memRdData[CMD_EOF_BIT];
            cmdPal   <= memRdData[CMD_PAL_BIT];
          end
        endcase
      end
      if (stb.loadDesc) begin
        curDescAddr <= descPtr;
        curSource   <= srcField;
        curFrameId  <= tagField;
        srcPtr      <= srcField;
        remain      <= lenField;
        palIdx      <= '0;
      end
      if (stb.burstInit) burstLeft <= burstSize;
      if (stb.dataIssue) begin
        srcPtr    <= srcPtr + 32'd4;
        remain    <= remain - 1'b1;
        burstLeft <= burstLeft - 1'b1;
      end
      rspValid <= stb.dataIssue;
      rspPal   <= cmdPal;
      if (palWrEn) palIdx <= palIdx + 1'b1;
    end
  end

  assign memRdEn = stb.descIssue | stb.dataIssue;
  assign memAddr = stb.descIssue ? (descPtr + {28'd0, descIdx, 2'b00}) : srcPtr;

  assign palWrEn   = rspValid & rspPal;
  assign palWrAddr = palIdx;
  assign palWrData = memRdData;

  assign fifoPush = rspValid & ~rspPal;
  assign fifoPop  = pixPop & ~fifoEmpty;

  pix_fifo #(.DEPTH(FIFO_DEPTH), .W(32), .CW(CW)) fifo_i (
    .clk(clk), .rstN(rstN),
    .push(fifoPush), .pushData(memRdData),
    .pop(fifoPop), .head(fifoHead),
    .empty(fifoEmpty), .count(fifoCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWord     <= '0;
      underrunFlag <= 1'b0;
    end else begin
      if (fifoPop) lastWord <= fifoHead;
      if (stb.start) underrunFlag <= 1'b0;
      else if (pixPop && fifoEmpty && underrunProt) underrunFlag <= 1'b1;
    end
  end

  assign pixValid = ~fifoEmpty | underrunProt;
  assign pixData  = fifoEmpty ? lastWord : fifoHead;

  always_comb begin
    info.descLast   = (descIdx == 2'd3);
    info.lenZero    = (lenField == '0);
    info.isPal      = cmdPal;
    info.fifoRoom   = (32'(fifoCount) + 32'(burstSize)) <= 32'(FIFO_DEPTH);
    info.lastIssue  = (burstLeft == 5'd1) || (remain == LEN_W'(1));
    info.remainZero = (remain == '0);
    info.wantSof    = cmdSof;
    info.wantEof    = cmdEof;
  end

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataIssue && $past(stb.dataIssue)) |-> (memAddr == $past(memAddr) + 32'd4));

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (underrunFlag && !stb.start) |=> underrunFlag);

endmodule

// File: rtl/frame_fetch_ctrl.sv
module frame_fetch_ctrl
  import frame_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  dp_info_t  info,
  output ctrl_stb_t stb,
  output logic      sofIrq,
  output logic      eofIrq
);
  fetch_state_t state, stateNext;
  logic         eofStb;

  always_comb begin
    stb       = '0;
    eofStb    = 1'b0;
    stateNext = state;
    case (state)
      S_IDLE: if (start) begin
        stb.start = 1'b1;
        stateNext = S_DRD;
      end
      S_DRD: begin
        stb.descIssue = 1'b1;
        stateNext     = S_DWT;
      end
      S_DWT: begin
        stb.descCapture = 1'b1;
        stateNext       = info.descLast ? S_LOAD : S_DRD;
      end
      S_LOAD: begin
        stb.loadDesc = 1'b1;
        if (info.lenZero) begin
          eofStb         = 1'b1;
          stb.followNext = 1'b1;
          stateNext      = S_DRD;
        end else begin
          stateNext = S_DATA;
        end
      end
      S_DATA: if (info.isPal || info.fifoRoom) begin
        stb.burstInit = 1'b1;
        stateNext     = S_BURST;
      end
      S_BURST: begin
        stb.dataIssue = 1'b1;
        if (info.lastIssue) stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (info.remainZero) begin
          eofStb         = 1'b1;
          stb.followNext = 1'b1;
          stateNext      = S_DRD;
        end else begin
          stateNext = S_DATA;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      sofIrq <= 1'b0;
      eofIrq <= 1'b0;
    end else begin
      state  <= stateNext;
      sofIrq <= stb.loadDesc & info.wantSof;
      eofIrq <= eofStb & info.wantEof;
    end
  end

  assert_sof_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    sofIrq |=> !sofIrq);

  assert_eof_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    eofIrq |=> !eofIrq);

endmodule

// File: rtl/frame_fetch_top.sv
module frame_fetch_top
  import frame_fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int PAL_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       startAddr,
  input  logic [1:0]        burstSel,
  input  logic              underrunProt,
  output logic              memRdEn,
  output logic [31:0]       memAddr,
  input  logic [31:0]       memRdData,
  output logic              palWrEn,
  output logic [PAL_AW-1:0] palWrAddr,
  output logic [31:0]       palWrData,
  input  logic              pixPop,
  output logic              pixValid,
  output logic [31:0]       pixData,
  output logic              sofIrq,
  output logic              eofIrq,
  output logic              underrunFlag,
  output logic [31:0]       curDescAddr,
  output logic [31:0]       curSource,
  output logic [31:0]       curFrameId
);
  ctrl_stb_t stb;
  dp_info_t  info;

  frame_fetch_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .info(info), .stb(stb),
    .sofIrq(sofIrq), .eofIrq(eofIrq)
  );

  frame_fetch_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .PAL_AW(PAL_AW)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .info(info),
    .startAddr(startAddr), .burstSel(burstSel), .underrunProt(underrunProt),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .palWrEn(palWrEn), .palWrAddr(palWrAddr), .palWrData(palWrData),
    .pixPop(pixPop), .pixValid(pixValid), .pixData(pixData),
    .underrunFlag(underrunFlag),
    .curDescAddr(curDescAddr), .curSource(curSource), .curFrameId(curFrameId)
  );

endmodule

// File: tb/frame_fetch_top_tb_top.sv
module frame_fetch_top_tb_top;
  localparam int DEPTH  = 32;
  localparam int PAL_AW = 8;
  localparam int WDOG   = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       startAddr = '0;
  logic [1:0]        burstSel = '0;
  logic              underrunProt = 1'b0;
  logic              memRdEn;
  logic [31:0]       memAddr;
  logic [31:0]       memRdData = '0;
  logic              palWrEn;
  logic [PAL_AW-1:0] palWrAddr;
  logic [31:0]       palWrData;
  logic              pixPop = 1'b0;
  logic              pixValid;
  logic [31:0]       pixData;
  logic              sofIrq, eofIrq, underrunFlag;
  logic [31:0]       curDescAddr, curSource, curFrameId;

  always #2.5 clk = ~clk;

  frame_fetch_top #(.FIFO_DEPTH(DEPTH), .PAL_AW(PAL_AW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .burstSel(burstSel), .underrunProt(underrunProt),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .palWrEn(palWrEn), .palWrAddr(palWrAddr), .palWrData(palWrData),
    .pixPop(pixPop), .pixValid(pixValid), .pixData(pixData),
    .sofIrq(sofIrq), .eofIrq(eofIrq), .underrunFlag(underrunFlag),
    .curDescAddr(curDescAddr), .curSource(curSource), .curFrameId(curFrameId)
  );

  logic [31:0] mem [1024];

  // memory model: one-cycle read latency
  always @(posedge clk) memRdData <= memRdEn ? mem[memAddr[11:2]] : 32'h0;

  int nChecks = 0, nFail = 0, cyc = 0;
  bit active = 1'b0;
  int popEvery = 0, expBurst = 4, runLen = 0;

  logic [31:0] qAddr[$];
  int          qKind[$];   // 0 descriptor, 1 palette, 2 frame
  logic [31:0] sofQ[$];
  logic [31:0] eofQ[$];
  string       eofTag[$];
  logic [31:0] palIdxQ[$];
  logic [31:0] palDatQ[$];
  logic [31:0] mFifo[$];
  logic [31:0] lastWord, prevWord;
  bit          mUnder, prevPal, prevFrame;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] v);
    mem[a[11:2]] = v;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endtask

  task automatic build_queues(input logic [31:0] first, input int nDesc);
    logic [31:0] p, cmd, src;
    int len;
    p = first;
    for (int d = 0; d < nDesc; d++) begin
      for (int k = 0; k < 4; k++) begin
        qAddr.push_back(p + 32'(4 * k));
        qKind.push_back(0);
      end
      src = rd(p + 32'd4);
      cmd = rd(p + 32'd12);
      len = int'(cmd[23:0]);
      if (cmd[31]) sofQ.push_back(p);
      for (int j = 0; j < len; j++) begin
        qAddr.push_back(src + 32'(4 * j));
        qKind.push_back(cmd[28] ? 1 : 2);
        if (cmd[28]) begin
          palIdxQ.push_back(32'(j));
          palDatQ.push_back(rd(src + 32'(4 * j)));
        end
      end
      if (cmd[30]) begin
        eofQ.push_back(p);
        eofTag.push_back(len == 0 ? "R8" : "R7");
      end
      p = rd(p);
    end
  endtask

  task automatic step();
    int kind;
    logic [31:0] w;
    bit doPop;
    @(negedge clk);
    cyc++;
    if (cyc > WDOG) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R1: actual=%0d expected=<%0d", cyc, WDOG);
      summary();
      $finish;
    end
    if (active) begin
      kind = 0;
      if (memRdEn && qAddr.size() > 0) begin
        kind = qKind.pop_front();
        w = qAddr.pop_front();
        check(memAddr == w, kind == 0 ? "R1" : "R2", memAddr, w);
      end
      // burst run lengths (R2)
      if (memRdEn && kind != 0) runLen++;
      else if (runLen > 0) begin
        check(runLen == expBurst, "R2", 32'(runLen), 32'(expBurst));
        runLen = 0;
      end
      // palette writes (R3)
      check(palWrEn == prevPal, "R3", 32'(palWrEn), 32'(prevPal));
      if (palWrEn && palIdxQ.size() > 0) begin
        w = palIdxQ.pop_front();
        check(32'(palWrAddr) == w, "R3", 32'(palWrAddr), w);
        w = palDatQ.pop_front();
        check(palWrData == w, "R3", palWrData, w);
      end
      // pixel stream (R4 / R10)
      if (mFifo.size() > 0) begin
        check(pixValid == 1'b1, "R4", 32'(pixValid), 32'd1);
        check(pixData == mFifo[0], "R4", pixData, mFifo[0]);
      end else if (underrunProt) begin
        check(pixValid == 1'b1, "R10", 32'(pixValid), 32'd1);
        check(pixData == lastWord, "R10", pixData, lastWord);
      end else begin
        check(pixValid == 1'b0, "R10", 32'(pixValid), 32'd0);
      end
      check(underrunFlag == mUnder, "R10", 32'(underrunFlag), 32'(mUnder));
      check(mFifo.size() <= DEPTH, "R5", 32'(mFifo.size()), 32'(DEPTH));
      // interrupts and status (R6, R7, R8, R9)
      if (sofIrq && sofQ.size() > 0) begin
        w = sofQ.pop_front();
        check(curDescAddr == w, "R6", curDescAddr, w);
        check(curSource == rd(w + 32'd4), "R9", curSource, rd(w + 32'd4));
        check(curFrameId == rd(w + 32'd8), "R9", curFrameId, rd(w + 32'd8));
      end
      if (eofIrq && eofQ.size() > 0) begin
        w = eofQ.pop_front();
        check(curDescAddr == w, eofTag.pop_front(), curDescAddr, w);
      end
      // advance the model to the next cycle
      doPop = (popEvery > 0) && ((cyc % popEvery) == 0);
      pixPop = doPop;
      if (doPop) begin
        if (mFifo.size() > 0) lastWord = mFifo.pop_front();
        else if (underrunProt) mUnder = 1'b1;
      end
      if (prevFrame) mFifo.push_back(prevWord);
      prevFrame = memRdEn && (kind == 2);
      prevPal   = memRdEn && (kind == 1);
      prevWord  = rd(memAddr);
    end
  endtask

  task automatic run_chain(input logic [31:0] first, input int nDesc, input logic [1:0] bsel,
                           input bit prot, input int popN, input bit resetCheck);
    rstN = 1'b0; start = 1'b0; pixPop = 1'b0;
    burstSel = bsel; underrunProt = prot; popEvery = popN;
    expBurst = (bsel == 2'd0) ? 4 : (bsel == 2'd1) ? 8 : 16;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    if (resetCheck) begin
      // R11 reset state
      check(memRdEn == 1'b0, "R11", 32'(memRdEn), 32'd0);
      check(palWrEn == 1'b0, "R11", 32'(palWrEn), 32'd0);
      check(sofIrq == 1'b0 && eofIrq == 1'b0, "R11", {30'd0, sofIrq, eofIrq}, 32'd0);
      check(underrunFlag == 1'b0, "R11", 32'(underrunFlag), 32'd0);
      check(pixValid == 1'b0, "R11", 32'(pixValid), 32'd0);
      check(curDescAddr == 0 && curSource == 0 && curFrameId == 0, "R11",
            curDescAddr | curSource | curFrameId, 32'd0);
    end
    qAddr.delete(); qKind.delete(); sofQ.delete(); eofQ.delete(); eofTag.delete();
    palIdxQ.delete(); palDatQ.delete(); mFifo.delete();
    build_queues(first, nDesc);
    lastWord = '0; prevWord = '0; mUnder = 1'b0; prevPal = 1'b0; prevFrame = 1'b0; runLen = 0;
    active = 1'b1;
    startAddr = first;
    start = 1'b1;
    step();
    start = 1'b0;
    while (qAddr.size() > 0) step();
    repeat (6) step();
    active = 1'b0;
    pixPop = 1'b0;
    check(sofQ.size() == 0, "R6", 32'(sofQ.size()), 32'd0);
    check(eofQ.size() == 0, "R7", 32'(eofQ.size()), 32'd0);
    check(palIdxQ.size() == 0, "R3", 32'(palIdxQ.size()), 32'd0);
  endtask

  initial begin
    fill_mem();
    // palette / frame loop, 8-word bursts, steady consumer, no guard
    wr(32'h100, 32'h200); wr(32'h104, 32'h400); wr(32'h108, 32'h11);
    wr(32'h10C, (32'd1 << 28) | 32'd8);
    wr(32'h200, 32'h100); wr(32'h204, 32'h800); wr(32'h208, 32'h22);
    wr(32'h20C, (32'd1 << 31) | (32'd1 << 30) | 32'd32);
    run_chain(32'h100, 5, 2'd1, 1'b0, 1, 1'b1);

    // zero-length descriptor, code 3 bursts, slow consumer fills the FIFO
    wr(32'h300, 32'h340); wr(32'h304, 32'h0); wr(32'h308, 32'h33);
    wr(32'h30C, (32'd1 << 31) | (32'd1 << 30));
    wr(32'h340, 32'h300); wr(32'h344, 32'hA00); wr(32'h348, 32'h44);
    wr(32'h34C, (32'd1 << 30) | 32'd48);
    run_chain(32'h300, 4, 2'd3, 1'b0, 5, 1'b0);

    // self-linked frame, 4-word bursts, guard on, consumer outruns fetch
    wr(32'h500, 32'h500); wr(32'h504, 32'hC00); wr(32'h508, 32'h55);
    wr(32'h50C, (32'd1 << 31) | 32'd4);
    run_chain(32'h500, 4, 2'd0, 1'b1, 1, 1'b0);

    // 16-word bursts through the plain code 2
    run_chain(32'h340, 2, 2'd2, 1'b0, 2, 1'b0);

    summary();
    $finish;
  end

endmodule